// File: doc/BRIEF.md
# Processor Bus Command Controller

This block sits between a processor that signals each bus transfer with a 3-bit status code and the memory, I/O and interrupt logic on a multiplexed address/data bus. It watches the status lines, and each time a transfer starts it pulses an address latch strobe. It sets the transceiver direction, enables the data transceiver and drives the matching active-low command strobe. Write transfers also get an early write strobe that asserts with read timing, so a slow device can start the write before the normal strobe.

A strap input picks one of two arbitration modes. In shared-bus mode every strobe waits until an arbitration grant input has been held low for a programmable number of clocks. In dedicated-I/O mode the I/O and interrupt-acknowledge strobes skip arbitration, and the dual-purpose output becomes an active-low enable for a peripheral-side transceiver. A command-enable input gates all strobes and data enables. Every output is registered, and timing is counted in whole clocks.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: Status decode (bus_status_i, bit 2 first): 000 interrupt acknowledge (inta), 001 I/O read (iord), 010 I/O write (iowr plus early aiowr), 011 halt (no strobe), 100 code fetch (mrd), 101 memory read (mrd), 110 memory write (mwr plus early amwr), 111 passive (no strobe). All strobes are active low.
- R2: A transfer starts on the first clock edge that samples a non-passive, non-halt code while the previous sampled code was 111. ale_o is high for exactly the one clock after that edge. Halt, passive, or a code reached from anything other than 111 gives no ale_o pulse and no transfer.
- R3: Read, fetch, interrupt-acknowledge and early-write strobes assert on the edge after the one that raised ale_o. The normal write strobe asserts one edge later.
- R4: The first edge that samples 111 during a transfer releases every strobe, den_o and the dual-purpose output, and returns dtr_o high.
- R5: dtr_o goes low at the ale_o edge for codes 000, 001, 100 and 101. It stays high for write transfers, halt and idle.
- R6: For read-type transfers (000, 001, 100, 101), den_o rises one edge after the strobe. For writes it rises on the same edge as the normal write strobe.
- R7: Shared-bus mode (io_strap_i = 0): no strobe asserts before the GRANT_DLY-th consecutive edge sampling arb_grant_n_i low. With the default of 2, the strobe appears on the second such edge.
- R8: An edge sampling arb_grant_n_i high releases all strobes in shared-bus mode, and the memory strobes in dedicated-I/O mode, at that edge.
- R9: Dedicated-I/O mode (io_strap_i = 1): iord, iowr, aiowr and inta ignore arb_grant_n_i entirely.
- R10: dual_o in shared-bus mode is an active-high cascade enable. It is high from the ale_o edge to the end of a 000 transfer and low otherwise. In dedicated-I/O mode it is an active-low peripheral enable: for codes 000, 001 and 010 it takes den_o's timing while den_o stays low. It is high otherwise.
- R11: An edge sampling cmd_en_i low leaves every strobe inactive, den_o low and the peripheral enable high after that edge.
- R12: cmd_oe_o (strobe output enable) goes high after an edge sampling io_strap_i high or arb_grant_n_i low, and low otherwise.
- R13: Synchronous active-low reset sets ale_o low, dtr_o high, den_o low, all strobes high and cmd_oe_o low. dual_o takes its inactive level (equal to io_strap_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_status_i | input | 3 | Processor status code |
| arb_grant_n_i | input | 1 | Bus arbitration grant, active low |
| cmd_en_i | input | 1 | Command enable, active high |
| io_strap_i | input | 1 | Mode strap: 0 shared bus, 1 dedicated I/O |
| ale_o | output | 1 | Address latch enable pulse |
| dtr_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den_o | output | 1 | System data transceiver enable, active high |
| dual_o | output | 1 | Cascade enable (high) or peripheral enable (low) |
| cmd_oe_o | output | 1 | Strobe output enable (0 models high impedance) |
| mrd_n_o | output | 1 | Memory read strobe |
| mwr_n_o | output | 1 | Memory write strobe |
| amwr_n_o | output | 1 | Early memory write strobe |
| iord_n_o | output | 1 | I/O read strobe |
| iowr_n_o | output | 1 | I/O write strobe |
| aiowr_n_o | output | 1 | Early I/O write strobe |
| inta_n_o | output | 1 | Interrupt acknowledge strobe |

## Verification
A corrupted latched status code shows up one edge after ale_o: the wrong strobe fires, or dtr_o has the wrong level at the ale_o edge itself. A phase counter that is off by one moves the normal write or den_o by a clock, and the bench catches this at the exact edge. A grant counter that saturates or clears wrongly makes a strobe appear one edge early or late after arb_grant_n_i falls, or makes it survive an edge where the grant is withdrawn. Mode-routing faults show as den_o and dual_o swapping roles during I/O transfers within two edges of the strobe.

// File: rtl/bcc_pkg.sv
// Package: shared status encoding, strobe indices and per-strobe attribute
// masks for the bus command controller.
// Assumes: strobe vectors are indexed with the IX_* constants below.
package bcc_pkg;

    typedef enum logic [2:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MRD   = 3'b101,
        ST_MWR   = 3'b110,
        ST_IDLE  = 3'b111
    } bus_stat_e;

    localparam int NCMD     = 7;
    localparam int IX_MRD   = 0;
    localparam int IX_MWR   = 1;
    localparam int IX_AMWR  = 2;
    localparam int IX_IORD  = 3;
    localparam int IX_IOWR  = 4;
    localparam int IX_AIOWR = 5;
    localparam int IX_INTA  = 6;

    // Strobes that assert in the read slot (everything except normal writes).
    localparam logic [NCMD-1:0] EARLY_MASK = 7'b1101101;
    // Strobes that bypass arbitration in dedicated-I/O mode.
    localparam logic [NCMD-1:0] IO_MASK    = 7'b1111000;
    // Strobes that move data toward the processor.
    localparam logic [NCMD-1:0] READ_MASK  = 7'b1001001;
    // Normal (late) write strobes.
    localparam logic [NCMD-1:0] NWR_MASK   = 7'b0010010;
    // Strobes that need arbitration in dedicated-I/O mode.
    localparam logic [NCMD-1:0] MEM_MASK   = 7'b0000111;

    // Map a status code to the set of strobes it drives.
    function automatic logic [NCMD-1:0] decode_cmds(input logic [2:0] s);
        logic [NCMD-1:0] m;
        m = '0;
        case (s)
            ST_INTA:  m[IX_INTA] = 1'b1;
            ST_IORD:  m[IX_IORD] = 1'b1;
            ST_IOWR:  begin m[IX_IOWR] = 1'b1; m[IX_AIOWR] = 1'b1; end
            ST_FETCH: m[IX_MRD]  = 1'b1;
            ST_MRD:   m[IX_MRD]  = 1'b1;
            ST_MWR:   begin m[IX_MWR] = 1'b1; m[IX_AMWR] = 1'b1; end
            default:  m = '0;
        endcase
        return m;
    endfunction

    // True for transfers whose data flows toward the processor.
    function automatic logic is_read_code(input logic [2:0] s);
        return (s == ST_INTA) || (s == ST_IORD) || (s == ST_FETCH) || (s == ST_MRD);
    endfunction

    // True for transfers that use the I/O side in dedicated-I/O mode.
    function automatic logic is_io_code(input logic [2:0] s);
        return (s == ST_INTA) || (s == ST_IORD) || (s == ST_IOWR);
    endfunction

endpackage

// File: rtl/bcc_cycle_seq.sv
// Module: transfer sequencer. Detects the start of a transfer, latches the
// status code, generates the address latch pulse and direction output, and
// tracks the phase within the transfer (1 = read slot, 2 = write slot).
// Assumes: status is sampled on the rising clock edge; reset is synchronous.
module bcc_cycle_seq
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] stat_i,
    output logic       start_o,
    output logic       cont_o,
    output logic       rd_slot_o,
    output logic       wr_slot_o,
    output logic [2:0] code_o,
    output logic       ale_o,
    output logic       dtr_o
);
    localparam logic [1:0] PH_LAST = 2'd2;

    logic [2:0] prev_q;
    logic [2:0] code_q;
    logic       in_cyc_q;
    logic [1:0] ph_q;
    logic       ale_q;
    logic       dtr_q;

    // Start when leaving passive for a code that opens a transfer.
    assign start_o   = (prev_q == ST_IDLE) && (stat_i != ST_IDLE) && (stat_i != ST_HALT);
    assign cont_o    = in_cyc_q && (stat_i != ST_IDLE);
    assign rd_slot_o = (ph_q != 2'd0);
    assign wr_slot_o = (ph_q == PH_LAST);
    assign code_o    = code_q;
    assign ale_o     = ale_q;
    assign dtr_o     = dtr_q;

    // Remember the last sampled status for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= ST_IDLE;
        else        prev_q <= stat_i;
    end

    // Track transfer occupancy, latched code and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cyc_q <= 1'b0;
            code_q   <= ST_IDLE;
            ph_q     <= 2'd0;
        end else if (start_o) begin
            in_cyc_q <= 1'b1;
            code_q   <= stat_i;
            ph_q     <= 2'd1;
        end else if (cont_o) begin
            if (ph_q != PH_LAST) ph_q <= ph_q + 2'd1;
        end else begin
            in_cyc_q <= 1'b0;
            ph_q     <= 2'd0;
        end
    end

    // Address latch pulse and transceiver direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            dtr_q <= 1'b1;
        end else begin
            ale_q <= start_o;
            if (start_o)               dtr_q <= !is_read_code(stat_i);
            else if (!cont_o)          dtr_q <= 1'b1;
        end
    end

    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);
    p_halt_no_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i == ST_HALT) |=> !ale_o);
    p_idle_dir_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i == ST_IDLE) |=> dtr_o);

endmodule

// File: rtl/bcc_arb_gate.sv
// Module: arbitration gate. Counts consecutive edges with the grant low and
// reports when strobes may be issued; also registers the strobe output enable.
// Assumes: GRANT_DLY >= 1; a single high sample of the grant resets the count.
module bcc_arb_gate #(
    parameter int GRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_n_i,
    input  logic iob_i,
    output logic grant_o,
    output logic oe_o
);
    localparam int CW = $clog2(GRANT_DLY + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(GRANT_DLY);
    localparam logic [CW-1:0] CNT_THR = CW'(GRANT_DLY - 1);

    logic [CW-1:0] cnt_q;
    logic          oe_q;

    assign grant_o = !grant_n_i && (cnt_q >= CNT_THR);
    assign oe_o    = oe_q;

    // Saturating count of consecutive low grant samples.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (grant_n_i)      cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Strobe drivers are enabled in dedicated-I/O mode or while granted.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= iob_i || !grant_n_i;
    end

    generate
        if (GRANT_DLY >= 2) begin : g_dly_chk
            p_grant_needs_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
                grant_o |-> !$past(grant_n_i));
        end
    endgenerate

    p_oe_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (iob_i || !grant_n_i) |=> oe_o);

endmodule

// File: rtl/bcc_strobe_gen.sv
// Module: strobe generator. Produces the registered command strobes (active
// high internally), the system data enable and the dual-purpose output.
// Assumes: slot and continuation flags come from the sequencer for the same edge.
module bcc_strobe_gen
    import bcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      stat_i,
    input  logic [2:0]      code_i,
    input  logic            start_i,
    input  logic            cont_i,
    input  logic            rd_slot_i,
    input  logic            wr_slot_i,
    input  logic            grant_i,
    input  logic            iob_i,
    input  logic            cen_i,
    output logic [NCMD-1:0] cmd_o,
    output logic            den_o,
    output logic            dual_o
);
    logic [NCMD-1:0] sel;
    logic [NCMD-1:0] nxt;
    logic [NCMD-1:0] cmd_q;
    logic            de_nxt;
    logic            to_pden;
    logic            mce_nxt;
    logic            den_q;
    logic            dual_q;

    assign sel = decode_cmds(code_i);

    // One registered strobe per command, gated by slot, grant and enable.
    for (genvar i = 0; i < NCMD; i++) begin : g_cmd
        logic slot_ok;
        logic gate_ok;
        assign slot_ok = EARLY_MASK[i] ? rd_slot_i : wr_slot_i;
        assign gate_ok = grant_i || (iob_i && IO_MASK[i]);
        assign nxt[i]  = cont_i && cen_i && sel[i] && slot_ok && gate_ok;

        // Register this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) cmd_q[i] <= 1'b0;
            else        cmd_q[i] <= nxt[i];
        end
    end

    // Data enable: one clock after read strobes, together with normal writes.
    always_comb begin
        if (is_read_code(code_i)) de_nxt = |(cmd_q & nxt & READ_MASK);
        else                      de_nxt = |(nxt & NWR_MASK);
    end

    assign to_pden = iob_i && is_io_code(code_i);
    assign mce_nxt = !iob_i && ((start_i && (stat_i == ST_INTA)) ||
                                (cont_i && (code_i == ST_INTA)));

    // Route the data enable and build the dual-purpose output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q  <= 1'b0;
            dual_q <= iob_i;
        end else begin
            den_q  <= de_nxt && !to_pden;
            dual_q <= iob_i ? !(de_nxt && to_pden) : mce_nxt;
        end
    end

    assign cmd_o  = cmd_q;
    assign den_o  = den_q;
    assign dual_o = dual_q;

    p_cen_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cen_i |=> ((cmd_o == '0) && !den_o));
    p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i == ST_IDLE) |=> ((cmd_o == '0) && !den_o));
    p_sys_waits_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!iob_i && !grant_i) |=> (cmd_o == '0));
    p_mem_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_i |=> ((cmd_o & MEM_MASK) == '0));
    p_strobe_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_o) <= 2);

endmodule

// File: rtl/bus_cmd_ctrl.sv
// Module: top of the bus command controller. Connects the sequencer, the
// arbitration gate and the strobe generator, and inverts strobes to active low.
// Assumes: all inputs are synchronous to clk; GRANT_DLY >= 1.
module bus_cmd_ctrl
    import bcc_pkg::*;
#(
    parameter int GRANT_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_status_i,
    input  logic       arb_grant_n_i,
    input  logic       cmd_en_i,
    input  logic       io_strap_i,
    output logic       ale_o,
    output logic       dtr_o,
    output logic       den_o,
    output logic       dual_o,
    output logic       cmd_oe_o,
    output logic       mrd_n_o,
    output logic       mwr_n_o,
    output logic       amwr_n_o,
    output logic       iord_n_o,
    output logic       iowr_n_o,
    output logic       aiowr_n_o,
    output logic       inta_n_o
);
    logic            start;
    logic            cont;
    logic            rd_slot;
    logic            wr_slot;
    logic [2:0]      code;
    logic            grant;
    logic [NCMD-1:0] cmd_act;

    bcc_cycle_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (bus_status_i),
        .start_o   (start),
        .cont_o    (cont),
        .rd_slot_o (rd_slot),
        .wr_slot_o (wr_slot),
        .code_o    (code),
        .ale_o     (ale_o),
        .dtr_o     (dtr_o)
    );

    bcc_arb_gate #(.GRANT_DLY(GRANT_DLY)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_n_i (arb_grant_n_i),
        .iob_i     (io_strap_i),
        .grant_o   (grant),
        .oe_o      (cmd_oe_o)
    );

    bcc_strobe_gen u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (bus_status_i),
        .code_i    (code),
        .start_i   (start),
        .cont_i    (cont),
        .rd_slot_i (rd_slot),
        .wr_slot_i (wr_slot),
        .grant_i   (grant),
        .iob_i     (io_strap_i),
        .cen_i     (cmd_en_i),
        .cmd_o     (cmd_act),
        .den_o     (den_o),
        .dual_o    (dual_o)
    );

    assign mrd_n_o   = !cmd_act[IX_MRD];
    assign mwr_n_o   = !cmd_act[IX_MWR];
    assign amwr_n_o  = !cmd_act[IX_AMWR];
    assign iord_n_o  = !cmd_act[IX_IORD];
    assign iowr_n_o  = !cmd_act[IX_IOWR];
    assign aiowr_n_o = !cmd_act[IX_AIOWR];
    assign inta_n_o  = !cmd_act[IX_INTA];

endmodule

// File: tb/bus_cmd_ctrl_tb_top.sv
module bus_cmd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat = 3'b111;
    logic       gnt_n = 1'b1;
    logic       cen = 1'b1;
    logic       iob = 1'b0;
    logic ale, dtr, den, dual, oe;
    logic mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, inta_n;
    logic [6:0] act;
    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_status_i(stat), .arb_grant_n_i(gnt_n),
        .cmd_en_i(cen), .io_strap_i(iob), .ale_o(ale), .dtr_o(dtr), .den_o(den),
        .dual_o(dual), .cmd_oe_o(oe), .mrd_n_o(mrd_n), .mwr_n_o(mwr_n),
        .amwr_n_o(amwr_n), .iord_n_o(iord_n), .iowr_n_o(iowr_n),
        .aiowr_n_o(aiowr_n), .inta_n_o(inta_n)
    );

    // Active-high strobe view: bit0 mrd,1 mwr,2 amwr,3 iord,4 iowr,5 aiowr,6 inta.
    assign act = ~{inta_n, aiowr_n, iowr_n, iord_n, amwr_n, mwr_n, mrd_n};

    // Vector: {iob, stat[2:0], gnt_n, cen, act[6:0], ale, dtr, den, dual, oe}
    localparam int NV = 56;
    localparam logic [17:0] VEC [NV] = '{
        // shared-bus memory read (R1 R3 R5 R6), release on passive (R4)
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        {1'b0,3'd5,1'b0,1'b1,7'h00,5'b10001},
        {1'b0,3'd5,1'b0,1'b1,7'h01,5'b00001},
        {1'b0,3'd5,1'b0,1'b1,7'h01,5'b00101},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // memory write: early strobe first, normal one edge later (R3)
        {1'b0,3'd6,1'b0,1'b1,7'h00,5'b11001},
        {1'b0,3'd6,1'b0,1'b1,7'h04,5'b01001},
        {1'b0,3'd6,1'b0,1'b1,7'h06,5'b01101},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // I/O read
        {1'b0,3'd1,1'b0,1'b1,7'h00,5'b10001},
        {1'b0,3'd1,1'b0,1'b1,7'h08,5'b00001},
        {1'b0,3'd1,1'b0,1'b1,7'h08,5'b00101},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // I/O write
        {1'b0,3'd2,1'b0,1'b1,7'h00,5'b11001},
        {1'b0,3'd2,1'b0,1'b1,7'h20,5'b01001},
        {1'b0,3'd2,1'b0,1'b1,7'h30,5'b01101},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // interrupt acknowledge with cascade enable (R10)
        {1'b0,3'd0,1'b0,1'b1,7'h00,5'b10011},
        {1'b0,3'd0,1'b0,1'b1,7'h40,5'b00011},
        {1'b0,3'd0,1'b0,1'b1,7'h40,5'b00111},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // halt: nothing (R2)
        {1'b0,3'd3,1'b0,1'b1,7'h00,5'b01001},
        {1'b0,3'd3,1'b0,1'b1,7'h00,5'b01001},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // code fetch
        {1'b0,3'd4,1'b0,1'b1,7'h00,5'b10001},
        {1'b0,3'd4,1'b0,1'b1,7'h01,5'b00001},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // grant delay (R7) and grant withdrawal (R8), oe (R12)
        {1'b0,3'd7,1'b1,1'b1,7'h00,5'b01000},
        {1'b0,3'd5,1'b1,1'b1,7'h00,5'b10000},
        {1'b0,3'd5,1'b1,1'b1,7'h00,5'b00000},
        {1'b0,3'd5,1'b0,1'b1,7'h00,5'b00001},
        {1'b0,3'd5,1'b0,1'b1,7'h01,5'b00001},
        {1'b0,3'd5,1'b0,1'b1,7'h01,5'b00101},
        {1'b0,3'd5,1'b1,1'b1,7'h00,5'b00000},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // command enable gating (R11)
        {1'b0,3'd2,1'b0,1'b0,7'h00,5'b11001},
        {1'b0,3'd2,1'b0,1'b0,7'h00,5'b01001},
        {1'b0,3'd2,1'b0,1'b1,7'h30,5'b01101},
        {1'b0,3'd2,1'b0,1'b0,7'h00,5'b01001},
        {1'b0,3'd7,1'b0,1'b1,7'h00,5'b01001},
        // dedicated-I/O mode: I/O read ignores grant (R9), peripheral enable (R10)
        {1'b1,3'd7,1'b1,1'b1,7'h00,5'b01011},
        {1'b1,3'd1,1'b1,1'b1,7'h00,5'b10011},
        {1'b1,3'd1,1'b1,1'b1,7'h08,5'b00011},
        {1'b1,3'd1,1'b1,1'b1,7'h08,5'b00001},
        {1'b1,3'd7,1'b1,1'b1,7'h00,5'b01011},
        // memory read still needs the grant (R8)
        {1'b1,3'd5,1'b1,1'b1,7'h00,5'b10011},
        {1'b1,3'd5,1'b1,1'b1,7'h00,5'b00011},
        {1'b1,3'd7,1'b1,1'b1,7'h00,5'b01011},
        // interrupt acknowledge on the I/O side
        {1'b1,3'd0,1'b1,1'b1,7'h00,5'b10011},
        {1'b1,3'd0,1'b1,1'b1,7'h40,5'b00011},
        {1'b1,3'd0,1'b1,1'b1,7'h40,5'b00001},
        {1'b1,3'd7,1'b1,1'b1,7'h00,5'b01011},
        // I/O write on the I/O side
        {1'b1,3'd2,1'b1,1'b1,7'h00,5'b11011},
        {1'b1,3'd2,1'b1,1'b1,7'h20,5'b01011},
        {1'b1,3'd2,1'b1,1'b1,7'h30,5'b01001},
        {1'b1,3'd7,1'b1,1'b1,7'h00,5'b01011}
    };

    task automatic chk(input string tag, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic step(input logic s_iob, input logic [2:0] s_stat,
                        input logic s_gnt_n, input logic s_cen);
        @(negedge clk);
        iob = s_iob; stat = s_stat; gnt_n = s_gnt_n; cen = s_cen;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // reset state (R13)
        repeat (3) @(posedge clk);
        #1;
        chk("R13 strobes", int'(act), 0);
        chk("R13 ale", int'(ale), 0);
        chk("R13 dtr", int'(dtr), 1);
        chk("R13 den", int'(den), 0);
        chk("R13 oe", int'(oe), 0);
        chk("R13 dual", int'(dual), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [17:0] e;
            e = VEC[v];
            step(e[17], e[16:14], e[13], e[12]);
            chk($sformatf("R1 R3 R7 R8 R9 R11 strobes v%0d", v), int'(act), int'(e[11:5]));
            chk($sformatf("R2 ale v%0d", v), int'(ale), int'(e[4]));
            chk($sformatf("R5 dtr v%0d", v), int'(dtr), int'(e[3]));
            chk($sformatf("R6 den v%0d", v), int'(den), int'(e[2]));
            chk($sformatf("R10 dual v%0d", v), int'(dual), int'(e[1]));
            chk($sformatf("R12 oe v%0d", v), int'(oe), int'(e[0]));
        end

        // R2: halt followed directly by a read code opens no transfer
        step(1'b0, 3'd7, 1'b0, 1'b1);
        step(1'b0, 3'd3, 1'b0, 1'b1);
        chk("R2 halt ale", int'(ale), 0);
        step(1'b0, 3'd5, 1'b0, 1'b1);
        chk("R2 halt-to-read ale", int'(ale), 0);
        step(1'b0, 3'd5, 1'b0, 1'b1);
        chk("R2 halt-to-read strobes", int'(act), 0);
        chk("R2 halt-to-read dtr", int'(dtr), 1);
        step(1'b0, 3'd7, 1'b0, 1'b1);

        // R13: reset in the middle of an active strobe, dedicated-I/O mode
        step(1'b1, 3'd1, 1'b1, 1'b1);
        chk("R13 pre ale", int'(ale), 1);
        step(1'b1, 3'd1, 1'b1, 1'b1);
        chk("R13 pre strobe", int'(act), 8);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R13 mid strobes", int'(act), 0);
        chk("R13 mid ale", int'(ale), 0);
        chk("R13 mid dtr", int'(dtr), 1);
        chk("R13 mid den", int'(den), 0);
        chk("R13 mid oe", int'(oe), 0);
        chk("R13 mid dual", int'(dual), 1);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 3'd7, 1'b1, 1'b1);
        chk("R4 after reset strobes", int'(act), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule